// File: doc/BRIEF.md
# LCD Panel Power-Mode Gate

This block sits between a display timing and data-fetch engine and the physical panel pins. Software writes a two-bit power-mode field through a small register port, and the block chooses between three operating states. In full operation it passes pixel data, the shift clock and the line, frame and data-ready sync pulses through to the panel, and it asks for display-memory words over a request/acknowledge handshake. In doze, meant for panels that keep their own image, the sync pulses keep running so the panel stays lit. The pixel bus and shift clock are parked low, and no memory read is requested. In power-save every panel pin is driven low and the line and frame counters stop.

A minimal line/frame counter inside the block produces the sync outputs. Mode changes wait for the end of the current frame, so no panel ever sees a truncated line or frame. The one exception is leaving power-save: that happens on the next clock, and the counters restart from the origin so the first frame after wake-up is whole. The register port works in every mode. Reset leaves the block in power-save until software selects another mode.

Top module: `lcd_pwr_gate`

## Requirements
- R1: After reset the block is in power-save. Every panel output and `fetch_req` is low, and `reg_rdata` reads 2'b00.
- R2: The mode field decodes as 2'b11 = run, 2'b10 = doze, 2'b00 = power-save, and the reserved value 2'b01 = power-save. `reg_rdata` returns the last raw value written, in any mode.
- R3: From run or doze, a new mode first applies in the cycle after the last cycle of a frame (line counter H_TOTAL-1, frame counter V_TOTAL-1). From power-save, it applies in the cycle after the write is sampled.
- R4: In power-save, `pix_data`, `pix_shift`, `line_sync`, `frame_sync`, `data_rdy` and `fetch_req` are all low, and the counters are held at zero.
- R5: In doze, `pix_data`, `pix_shift` and `fetch_req` are low. `line_sync`, `frame_sync` and `data_rdy` follow the same timing as in run.
- R6: In run or doze, `line_sync` is high when the line counter is 0, and `frame_sync` is high when both counters are 0. `data_rdy` is high when the line counter is at least H_BLANK. In run, `pix_data` equals `eng_data` while `data_rdy` is high and is 0 otherwise. `pix_shift` is high in data-ready cycles whose line counter is odd.
- R7: The first cycle after leaving power-save has both counters at zero, so `line_sync` and `frame_sync` are both high in that cycle.
- R8: In run, a request is raised in the cycle after a data-ready cycle in which none was pending. It is held until `fetch_ack` is sampled high, and dropped in the following cycle. `fetch_req` is low in every cycle in which the block is not in run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Mode field write strobe |
| reg_wdata | input | 2 | Mode field write value |
| reg_rdata | output | 2 | Mode field readback |
| eng_data | input | 12 | Pixel word from the fetch engine |
| fetch_ack | input | 1 | Memory fetch acknowledge |
| fetch_req | output | 1 | Memory fetch request |
| pix_data | output | 12 | Panel pixel data bus |
| pix_shift | output | 1 | Panel shift clock |
| line_sync | output | 1 | Panel line pulse |
| frame_sync | output | 1 | Panel frame pulse |
| data_rdy | output | 1 | Panel data-ready strobe |

## Verification
The bound checker enforces the following on every cycle:
- every output stays quiet in power-save;
- the data bus, shift clock and request stay parked in doze;
- a frame pulse always coincides with a line pulse;
- the active mode moves only at a frame end or out of power-save;
- a wake-up lands on the frame origin;
- an unacknowledged request is held.

Only the bench's scenarios can show the following:
- the exact cycle in which a mid-frame write takes effect;
- the reserved code landing in power-save and reading back unchanged;
- pixel pass-through under changing data;
- request timing under each acknowledge pattern.

The bench's reference model predicts every output on every cycle to cover these.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

  // Encodings match the software-visible mode field.
  typedef enum logic [1:0] {
    PM_SAVE = 2'b00,
    PM_DOZE = 2'b10,
    PM_RUN  = 2'b11
  } pmode_e;

  // Reserved code falls to the lowest-power state.
  function automatic pmode_e decode_mode(input logic [1:0] field);
    case (field)
      2'b11:   decode_mode = PM_RUN;
      2'b10:   decode_mode = PM_DOZE;
      default: decode_mode = PM_SAVE;
    endcase
  endfunction

endpackage

// File: rtl/lcd_mode_ctrl.sv
module lcd_mode_ctrl
  import lcd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_field,
  input  logic       frame_end,
  output logic [1:0] field_q,
  output pmode_e     mode_q
);

  logic [1:0] field_d;
  pmode_e     mode_d;
  logic       apply_en;

  always_comb begin
    field_d  = wr_en ? wr_field : field_q;
    // Power-save has no frame in progress: any cycle is a boundary.
    apply_en = (mode_q == PM_SAVE) || frame_end;
    mode_d   = apply_en ? decode_mode(field_q) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= 2'b00;
      mode_q  <= PM_SAVE;
    end else begin
      if (wr_en)    field_q <= field_d;
      if (apply_en) mode_q  <= mode_d;
    end
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int H_TOTAL = 10,
  parameter int V_TOTAL = 4,
  parameter int H_BLANK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic line_pulse,
  output logic frame_pulse,
  output logic active,
  output logic odd_px,
  output logic frame_end
);

  localparam int HW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1;
  localparam int VW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(H_BLANK);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          line_end;

  always_comb begin
    line_end  = (h_q == H_LAST);
    frame_end = run_en && line_end && (v_q == V_LAST);
    h_d = h_q;
    v_d = v_q;
    if (!run_en) begin
      h_d = '0;
      v_d = '0;
    end else if (line_end) begin
      h_d = '0;
      v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign line_pulse  = run_en && (h_q == '0);
  assign frame_pulse = line_pulse && (v_q == '0);
  assign active      = run_en && (h_q >= H_ACT);
  assign odd_px      = h_q[0];

endmodule

// File: rtl/lcd_out_gate.sv
module lcd_out_gate
  import lcd_pwr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pmode_e            mode,
  input  logic              line_pulse,
  input  logic              frame_pulse,
  input  logic              active,
  input  logic              odd_px,
  input  logic [DATA_W-1:0] src_data,
  input  logic              fetch_ack,
  output logic              fetch_req,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_shift,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              data_rdy
);

  logic run_m, sync_m, pix_en;
  logic pend_q, pend_d;

  always_comb begin
    run_m  = (mode == PM_RUN);
    sync_m = (mode == PM_RUN) || (mode == PM_DOZE);
    pix_en = run_m && active;
    pend_d = run_m && (pend_q ? !fetch_ack : active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // Per-bit park of the pixel bus.
  for (genvar b = 0; b < DATA_W; b++) begin : g_pix
    assign pix_data[b] = pix_en & src_data[b];
  end

  assign pix_shift  = pix_en && odd_px;
  assign line_sync  = sync_m && line_pulse;
  assign frame_sync = sync_m && frame_pulse;
  assign data_rdy   = sync_m && active;
  assign fetch_req  = run_m && pend_q;

endmodule

// File: rtl/lcd_pwr_gate.sv
module lcd_pwr_gate
  import lcd_pwr_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int H_TOTAL = 10,
  parameter int V_TOTAL = 4,
  parameter int H_BLANK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_wdata,
  output logic [1:0]        reg_rdata,
  input  logic [DATA_W-1:0] eng_data,
  input  logic              fetch_ack,
  output logic              fetch_req,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_shift,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              data_rdy
);

  logic [1:0] rst_pipe;
  logic       rst_sn;
  pmode_e     mode_q;
  logic       frame_end, line_pulse, frame_pulse, active, odd_px, run_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign run_en = (mode_q != PM_SAVE);

  lcd_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en     (reg_we),
    .wr_field  (reg_wdata),
    .frame_end (frame_end),
    .field_q   (reg_rdata),
    .mode_q    (mode_q)
  );

  lcd_sync_gen #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .H_BLANK (H_BLANK)
  ) u_sync (
    .clk         (clk),
    .rst_n       (rst_sn),
    .run_en      (run_en),
    .line_pulse  (line_pulse),
    .frame_pulse (frame_pulse),
    .active      (active),
    .odd_px      (odd_px),
    .frame_end   (frame_end)
  );

  lcd_out_gate #(
    .DATA_W (DATA_W)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_sn),
    .mode        (mode_q),
    .line_pulse  (line_pulse),
    .frame_pulse (frame_pulse),
    .active      (active),
    .odd_px      (odd_px),
    .src_data    (eng_data),
    .fetch_ack   (fetch_ack),
    .fetch_req   (fetch_req),
    .pix_data    (pix_data),
    .pix_shift   (pix_shift),
    .line_sync   (line_sync),
    .frame_sync  (frame_sync),
    .data_rdy    (data_rdy)
  );

endmodule

// File: rtl/lcd_pwr_gate_chk.sv
module lcd_pwr_gate_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              last_cyc,
  input logic [DATA_W-1:0] pix_data,
  input logic              pix_shift,
  input logic              line_sync,
  input logic              frame_sync,
  input logic              data_rdy,
  input logic              fetch_req,
  input logic              fetch_ack
);

  p_save_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (pix_data == '0 && !pix_shift && !line_sync &&
                         !frame_sync && !data_rdy && !fetch_req));

  p_doze_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (pix_data == '0 && !pix_shift && !fetch_req));

  p_frame_in_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> line_sync);

  p_mode_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(mode) == 2'b00 || $past(last_cyc)));

  p_wake_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00 && mode != 2'b00) |-> (frame_sync && line_sync));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req || mode != 2'b11));

endmodule

bind lcd_pwr_gate lcd_pwr_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .mode       (mode_q),
  .last_cyc   (frame_end),
  .pix_data   (pix_data),
  .pix_shift  (pix_shift),
  .line_sync  (line_sync),
  .frame_sync (frame_sync),
  .data_rdy   (data_rdy),
  .fetch_req  (fetch_req),
  .fetch_ack  (fetch_ack)
);

// File: tb/lcd_pwr_gate_bench.sv
`timescale 1ns/1ps
module lcd_pwr_gate_bench;

  localparam int DW = 12;
  localparam int HT = 10;
  localparam int VT = 4;
  localparam int HB = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [1:0]    reg_wdata;
  logic [1:0]    reg_rdata;
  logic [DW-1:0] eng_data;
  logic          fetch_ack;
  logic          fetch_req;
  logic [DW-1:0] pix_data;
  logic          pix_shift, line_sync, frame_sync, data_rdy;

  always #2.5 clk = ~clk;

  lcd_pwr_gate #(.DATA_W(DW), .H_TOTAL(HT), .V_TOTAL(VT), .H_BLANK(HB)) u_lcd_pwr_gate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eng_data(eng_data), .fetch_ack(fetch_ack),
    .fetch_req(fetch_req), .pix_data(pix_data), .pix_shift(pix_shift),
    .line_sync(line_sync), .frame_sync(frame_sync), .data_rdy(data_rdy)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";
  int    ack_mode = 0;
  int    cyc = 0;

  // Reference state: mode 0 save, 1 doze, 2 run.
  int m_mode, m_raw, m_h, m_v, m_pend;

  function automatic int dec(input int raw);
    if (raw == 3) return 2;
    if (raw == 2) return 1;
    return 0;   // 00 and reserved 01 (R2)
  endfunction

  // Input drivers, away from the active edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    eng_data  = DW'((cyc * 37 + 5) & 12'hFFF);
    fetch_ack = (ack_mode == 1) ? 1'b1 : (ack_mode == 2) ? (cyc % 3 == 0) : 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_raw = 0; m_h = 0; m_v = 0; m_pend = 0;
    end else begin
      bit last, bnd, de;
      int nxt;
      last = (m_h == HT - 1) && (m_v == VT - 1);
      bnd  = (m_mode == 0) || last;
      de   = (m_mode != 0) && (m_h >= HB);
      nxt  = bnd ? dec(m_raw) : m_mode;
      m_pend = (m_mode == 2) ? (m_pend ? !fetch_ack : de) : 0;
      if (m_mode == 0) begin
        m_h = 0; m_v = 0;
      end else if (m_h == HT - 1) begin
        m_h = 0; m_v = (m_v == VT - 1) ? 0 : m_v + 1;
      end else m_h = m_h + 1;
      m_mode = nxt;
      if (reg_we) m_raw = reg_wdata;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge (R1..R8 by scenario tag).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit de, run, on;
      on  = (m_mode != 0);
      run = (m_mode == 2);
      de  = on && (m_h >= HB);
      check("reg_rdata",  32'(reg_rdata),  32'(m_raw));
      check("line_sync",  32'(line_sync),  32'(on && m_h == 0));
      check("frame_sync", 32'(frame_sync), 32'(on && m_h == 0 && m_v == 0));
      check("data_rdy",   32'(data_rdy),   32'(de));
      check("pix_shift",  32'(pix_shift),  32'(run && de && (m_h % 2 == 1)));
      check("pix_data",   32'(pix_data),   (run && de) ? 32'(eng_data) : 32'd0);
      check("fetch_req",  32'(fetch_req),  32'(run && m_pend != 0));
    end
  end

  task automatic wr(input logic [1:0] v);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_wdata = v;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = 2'b00;
    eng_data = '0; fetch_ack = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    tag = "R1"; idle(8);                       // reset state: save, all low
    tag = "R2"; wr(2'b01); idle(20);           // reserved code stays save, reads back 01
    tag = "R7"; ack_mode = 2; wr(2'b11); idle(3);  // wake at frame origin
    tag = "R6"; idle(80);                      // run: pass-through and sync timing
    tag = "R8"; ack_mode = 0; idle(20);        // request held without ack
    ack_mode = 1; idle(30);                    // ack every cycle
    ack_mode = 2; idle(7);
    tag = "R3"; wr(2'b10); idle(45);           // mid-frame write waits for boundary
    tag = "R5"; idle(60);                      // doze: sync runs, data parked
    tag = "R3"; wr(2'b11); idle(60);           // back to run at boundary
    tag = "R4"; wr(2'b01); idle(100);          // reserved from run, save at boundary
    tag = "R7"; wr(2'b11); idle(50);           // wake restarts counters
    tag = "R3"; wr(2'b00); idle(50);           // enter save at boundary
    tag = "R2"; wr(2'b10); idle(60);           // doze straight from save
    done = 1;
    summary();
    $finish;
  end

endmodule